// File: doc/BRIEF.md
# Closed-Loop Fan Duty Controller

This block keeps a cooling fan at the speed the current temperature calls for. It first forms an effective temperature from a measured reading and a signed per-channel correction. It then looks that temperature up on a curve and gets the tachometer count the fan should show. On every update tick it moves an 8-bit PWM duty one step toward the duty that makes the measured count equal that expected count. A larger count means a slower fan.

The curve comes from three programmed temperature boundaries and four programmed counts. The block inserts the floor-average of each adjacent pair of boundaries, which gives five boundaries and six zones. The zones between the programmed ones get averaged counts. Two other modes bypass the curve. In speed mode one programmed count is the target. In manual mode the duty is written directly.

Near standstill the loop does not hunt. A fan slowed down to the stop duty is switched off, and a stopped fan that must spin is kicked to the start duty. Either duty is then frozen for a programmable number of ticks. An over-temperature flag with hysteresis and a fan-fault flag for a fan that stays too slow at full duty complete the block.

Top module: `fan_auto_ctrl`

## Requirements
- R1: While reset is asserted, `duty` is 8'hFF and `hot` and `fan_fault` are 0.
- R2: With `mode` = 2'b00 (manual), `duty` takes the value of `manual_duty` at the next clock edge, with or without `tick`.
- R3: With `mode` = 2'b10 or 2'b11 (temperature), the expected count is chosen from the effective temperature T. The boundaries are B0 = `bnd0`, B2 = `bnd1`, B4 = `bnd2`, B1 = floor((B0+B2)/2) and B3 = floor((B2+B4)/2); they are programmed ascending. The count is then `zcnt0` for T < B0, floor((zcnt0+zcnt1)/2) for B0 <= T < B1, `zcnt1` for B1 <= T < B2, floor((zcnt1+zcnt2)/2) for B2 <= T < B3, `zcnt2` for B3 <= T < B4, and `zcnt3` for T >= B4.
- R4: T equals `temp_raw` plus `temp_adj`, where `temp_adj` is read as 7-bit two's complement. The result is clamped to the range 0 to 255.
- R5: With `mode` = 2'b01 (speed), the expected count is `speed_target`.
- R6: On a `tick` outside a hold and outside the forced cases, `duty` rises by 1 if `fan_count` is above the expected count. It falls by 1 if `fan_count` is below it, and stays the same if they are equal. It saturates at 8'hFF and 8'h00.
- R7: On a `tick` in a closed-loop mode, an expected count of 16'hFFFF sets `duty` to 8'h00 and an expected count of 16'h0000 sets it to 8'hFF. Both cancel any hold.
- R8: When a decrease is due, `duty` equals a nonzero `stop_duty`, and no hold is running, `duty` becomes 8'h00. The next `hold_ticks` ticks then leave `duty` unchanged whatever `fan_count` does.
- R9: When an increase is due, `duty` is 8'h00, and no hold is running, `duty` becomes `start_duty`. The next `hold_ticks` ticks then leave `duty` unchanged.
- R10: `fan_fault` becomes 1 after `fault_ticks` consecutive ticks in a closed-loop mode with `duty` = 8'hFF and `fan_count` above a nonzero expected count. It returns to 0 one clock after that condition stops holding.
- R11: `hot` sets one clock after T exceeds `hot_limit` and clears one clock after T falls below `hot_release`. Between the two it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle update strobe for the loop |
| mode | input | 2 | 00 manual, 01 speed, 10/11 temperature |
| manual_duty | input | 8 | Duty used in manual mode |
| speed_target | input | 16 | Expected count in speed mode |
| temp_raw | input | 8 | Measured temperature, unsigned degrees |
| temp_adj | input | 7 | Signed correction added to the temperature |
| fan_count | input | 16 | Measured tachometer count |
| bnd0 | input | 8 | Lowest programmed boundary |
| bnd1 | input | 8 | Middle programmed boundary |
| bnd2 | input | 8 | Highest programmed boundary |
| zcnt0 | input | 16 | Count below the lowest boundary |
| zcnt1 | input | 16 | Count between the lower programmed boundaries |
| zcnt2 | input | 16 | Count between the upper programmed boundaries |
| zcnt3 | input | 16 | Count at or above the highest boundary |
| stop_duty | input | 8 | Duty from which the fan is switched off |
| start_duty | input | 8 | Duty a stopped fan is kicked to |
| hold_ticks | input | 16 | Freeze length after a stop or start, in ticks |
| fault_ticks | input | 16 | Ticks at full duty before a fault is flagged |
| hot_limit | input | 8 | Over-temperature set threshold |
| hot_release | input | 8 | Over-temperature clear threshold |
| duty | output | 8 | PWM duty |
| hot | output | 1 | Over-temperature flag |
| fan_fault | output | 1 | Fan fault flag |

## Verification
The assertions take `tick` to be a single-cycle strobe. They assume the three boundaries are programmed ascending, `start_duty` is nonzero, `fault_ticks` is at least one, and `hot_release` is not above `hot_limit`. The stimulus changes inputs only on falling edges and keeps every programmed value inside those limits. Zone selection is probed by placing `fan_count` equal to, one above and one below the expected count from a mid-scale duty. This pins the count exactly without ever reaching the stop or start thresholds.

// File: rtl/fan_ctrl_pkg.sv
package fan_ctrl_pkg;

   typedef enum logic [1:0] {
      FM_MANUAL   = 2'b00,
      FM_SPEED    = 2'b01,
      FM_TEMP     = 2'b10,
      FM_TEMP_ALT = 2'b11
   } fan_mode_e;

   localparam int USER_BND  = 3;
   localparam int ALL_BND   = 2 * USER_BND - 1;
   localparam int ALL_ZONE  = ALL_BND + 1;

endpackage

// File: rtl/fan_temp_front.sv
module fan_temp_front #(
   parameter int TEMP_W    = 8,
   parameter int OFS_W     = 7,
   parameter bit OFS_CLAMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TEMP_W-1:0] temp_raw,
   input  logic [OFS_W-1:0]  temp_adj,
   input  logic [TEMP_W-1:0] hot_limit,
   input  logic [TEMP_W-1:0] hot_release,
   output logic [TEMP_W-1:0] temp_eff,
   output logic              hot
);
   localparam int SW = TEMP_W + 2;

   logic signed [SW-1:0] s_raw;
   logic signed [SW-1:0] s_adj;
   logic signed [SW-1:0] s_sum;
   logic                 hot_q;

   assign s_raw = $signed({2'b00, temp_raw});
   assign s_adj = $signed({{(SW-OFS_W){temp_adj[OFS_W-1]}}, temp_adj});
   assign s_sum = s_raw + s_adj;

   generate
      if (OFS_CLAMP) begin : g_clamp
         always_comb begin
            if (s_sum[SW-1])
               temp_eff = '0;
            else if (s_sum[SW-2])
               temp_eff = '1;
            else
               temp_eff = s_sum[TEMP_W-1:0];
         end
      end else begin : g_wrap
         assign temp_eff = s_sum[TEMP_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hot_q <= 1'b0;
      else if (temp_eff > hot_limit)
         hot_q <= 1'b1;
      else if (temp_eff < hot_release)
         hot_q <= 1'b0;
   end

   assign hot = hot_q;

   a_r11_keep_set: assert property (@(posedge clk) disable iff (!rst_n)
      (hot_q && temp_eff >= hot_release) |=> hot_q);
   a_r11_keep_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (!hot_q && temp_eff <= hot_limit) |=> !hot_q);
   a_r4_clamp_top: assert property (@(posedge clk) disable iff (!rst_n)
      (OFS_CLAMP && !temp_adj[OFS_W-1]) |-> (temp_eff >= temp_raw));
   a_r4_clamp_bottom: assert property (@(posedge clk) disable iff (!rst_n)
      (OFS_CLAMP && temp_adj[OFS_W-1]) |-> (temp_eff <= temp_raw));

endmodule

// File: rtl/fan_curve_map.sv
module fan_curve_map
   import fan_ctrl_pkg::*;
#(
   parameter int TEMP_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic [TEMP_W-1:0]                 temp_eff,
   input  logic [USER_BND-1:0][TEMP_W-1:0]  bnd_user,
   input  logic [USER_BND:0][CNT_W-1:0]     cnt_user,
   output logic [CNT_W-1:0]                  exp_cnt
);
   localparam int ZIDX_W = $clog2(ALL_ZONE);

   logic [ALL_BND-1:0][TEMP_W-1:0]  bnd_all;
   logic [ALL_ZONE-1:0][CNT_W-1:0]  zone_cnt;
   logic [ALL_BND-1:0]              at_or_above;
   logic [ZIDX_W-1:0]               zone;

   generate
      for (genvar k = 0; k < USER_BND; k++) begin : g_user
         assign bnd_all[2*k]  = bnd_user[k];
         assign zone_cnt[2*k] = cnt_user[k];
      end
      for (genvar k = 0; k < USER_BND - 1; k++) begin : g_mid
         logic [TEMP_W:0] b_sum;
         logic [CNT_W:0]  c_sum;
         assign b_sum           = {1'b0, bnd_user[k]} + {1'b0, bnd_user[k+1]};
         assign c_sum           = {1'b0, cnt_user[k]} + {1'b0, cnt_user[k+1]};
         assign bnd_all[2*k+1]  = b_sum[TEMP_W:1];
         assign zone_cnt[2*k+1] = c_sum[CNT_W:1];
      end
      assign zone_cnt[ALL_ZONE-1] = cnt_user[USER_BND];
      for (genvar k = 0; k < ALL_BND; k++) begin : g_cmp
         assign at_or_above[k] = (temp_eff >= bnd_all[k]);
      end
   endgenerate

   assign zone    = ZIDX_W'($countones(at_or_above));
   assign exp_cnt = zone_cnt[zone];

endmodule

// File: rtl/fan_duty_loop.sv
module fan_duty_loop #(
   parameter int DUTY_W = 8,
   parameter int CNT_W  = 16,
   parameter int HOLD_W = 16,
   parameter int FLT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              closed,
   input  logic [DUTY_W-1:0] manual_duty,
   input  logic [CNT_W-1:0]  exp_cnt,
   input  logic [CNT_W-1:0]  fan_count,
   input  logic [DUTY_W-1:0] stop_duty,
   input  logic [DUTY_W-1:0] start_duty,
   input  logic [HOLD_W-1:0] hold_ticks,
   input  logic [FLT_W-1:0]  fault_ticks,
   output logic [DUTY_W-1:0] duty,
   output logic              fan_fault
);
   localparam logic [DUTY_W-1:0] DMAX = '1;
   localparam logic [CNT_W-1:0]  CMAX = '1;
   localparam logic [FLT_W-1:0]  FMAX = '1;

   logic [DUTY_W-1:0] duty_q;
   logic [HOLD_W-1:0] hold_q;
   logic [FLT_W-1:0]  flt_cnt;
   logic              flt_q;
   logic              forced;
   logic              too_slow;
   logic              too_fast;
   logic              stall_cond;

   assign forced     = (exp_cnt == CMAX) || (exp_cnt == '0);
   assign too_slow   = fan_count > exp_cnt;
   assign too_fast   = fan_count < exp_cnt;
   assign stall_cond = closed && (duty_q == DMAX) && (exp_cnt != '0) && too_slow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty_q <= DMAX;
         hold_q <= '0;
      end else if (!closed) begin
         duty_q <= manual_duty;
         hold_q <= '0;
      end else if (tick) begin
         if (exp_cnt == CMAX) begin
            duty_q <= '0;
            hold_q <= '0;
         end else if (exp_cnt == '0) begin
            duty_q <= DMAX;
            hold_q <= '0;
         end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
         end else if (too_slow) begin
            if (duty_q == '0) begin
               duty_q <= start_duty;
               hold_q <= hold_ticks;
            end else if (duty_q != DMAX) begin
               duty_q <= duty_q + 1'b1;
            end
         end else if (too_fast && duty_q != '0) begin
            if (stop_duty != '0 && duty_q == stop_duty) begin
               duty_q <= '0;
               hold_q <= hold_ticks;
            end else begin
               duty_q <= duty_q - 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flt_cnt <= '0;
         flt_q   <= 1'b0;
      end else if (!stall_cond) begin
         flt_cnt <= '0;
         flt_q   <= 1'b0;
      end else if (tick) begin
         if ({1'b0, flt_cnt} + 1'b1 >= {1'b0, fault_ticks})
            flt_q <= 1'b1;
         if (flt_cnt != FMAX)
            flt_cnt <= flt_cnt + 1'b1;
      end
   end

   assign duty      = duty_q;
   assign fan_fault = flt_q;

   a_r2_manual_follow: assert property (@(posedge clk) disable iff (!rst_n)
      !closed |=> (duty == $past(manual_duty)));
   a_r6_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      (closed && tick && !forced && hold_q == '0 && duty_q != '0 &&
       !(too_fast && duty_q == stop_duty))
      |=> (duty == $past(duty) || duty == $past(duty) + 1'b1 || duty == $past(duty) - 1'b1));
   a_r8_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (closed && hold_q != '0 && !forced) |=> $stable(duty));
   a_r7_force_off: assert property (@(posedge clk) disable iff (!rst_n)
      (closed && tick && exp_cnt == CMAX) |=> (duty == '0));
   a_r7_force_full: assert property (@(posedge clk) disable iff (!rst_n)
      (closed && tick && exp_cnt == '0) |=> (duty == DMAX));
   a_r10_fault_at_full: assert property (@(posedge clk) disable iff (!rst_n)
      fan_fault |-> ($past(duty) == DMAX));
   a_r10_fault_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (fan_fault && fan_count <= exp_cnt) |=> !fan_fault);

endmodule

// File: rtl/fan_auto_ctrl.sv
module fan_auto_ctrl
   import fan_ctrl_pkg::*;
#(
   parameter int DUTY_W    = 8,
   parameter int CNT_W     = 16,
   parameter int TEMP_W    = 8,
   parameter int OFS_W     = 7,
   parameter int HOLD_W    = 16,
   parameter int FLT_W     = 16,
   parameter bit OFS_CLAMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [1:0]        mode,
   input  logic [DUTY_W-1:0] manual_duty,
   input  logic [CNT_W-1:0]  speed_target,
   input  logic [TEMP_W-1:0] temp_raw,
   input  logic [OFS_W-1:0]  temp_adj,
   input  logic [CNT_W-1:0]  fan_count,
   input  logic [TEMP_W-1:0] bnd0,
   input  logic [TEMP_W-1:0] bnd1,
   input  logic [TEMP_W-1:0] bnd2,
   input  logic [CNT_W-1:0]  zcnt0,
   input  logic [CNT_W-1:0]  zcnt1,
   input  logic [CNT_W-1:0]  zcnt2,
   input  logic [CNT_W-1:0]  zcnt3,
   input  logic [DUTY_W-1:0] stop_duty,
   input  logic [DUTY_W-1:0] start_duty,
   input  logic [HOLD_W-1:0] hold_ticks,
   input  logic [FLT_W-1:0]  fault_ticks,
   input  logic [TEMP_W-1:0] hot_limit,
   input  logic [TEMP_W-1:0] hot_release,
   output logic [DUTY_W-1:0] duty,
   output logic              hot,
   output logic              fan_fault
);
   generate
      if (OFS_W >= TEMP_W) begin : g_bad_ofs
         $error("offset must be narrower than the temperature");
      end
      if (DUTY_W < 2 || CNT_W < 2) begin : g_bad_width
         $error("duty and count need at least two bits");
      end
      if (HOLD_W < 1 || FLT_W < 1) begin : g_bad_timer
         $error("timer widths must be positive");
      end
   endgenerate

   fan_mode_e                         mode_e;
   logic [TEMP_W-1:0]                 temp_eff;
   logic [CNT_W-1:0]                  curve_cnt;
   logic [CNT_W-1:0]                  exp_cnt;
   logic                              closed;
   logic [USER_BND-1:0][TEMP_W-1:0]   bnd_vec;
   logic [USER_BND:0][CNT_W-1:0]      cnt_vec;

   assign mode_e  = fan_mode_e'(mode);
   assign closed  = (mode_e != FM_MANUAL);
   assign bnd_vec = {bnd2, bnd1, bnd0};
   assign cnt_vec = {zcnt3, zcnt2, zcnt1, zcnt0};
   assign exp_cnt = (mode_e == FM_SPEED) ? speed_target : curve_cnt;

   fan_temp_front #(
      .TEMP_W    (TEMP_W),
      .OFS_W     (OFS_W),
      .OFS_CLAMP (OFS_CLAMP)
   ) u_front (
      .clk         (clk),
      .rst_n       (rst_n),
      .temp_raw    (temp_raw),
      .temp_adj    (temp_adj),
      .hot_limit   (hot_limit),
      .hot_release (hot_release),
      .temp_eff    (temp_eff),
      .hot         (hot)
   );

   fan_curve_map #(
      .TEMP_W (TEMP_W),
      .CNT_W  (CNT_W)
   ) u_curve (
      .temp_eff (temp_eff),
      .bnd_user (bnd_vec),
      .cnt_user (cnt_vec),
      .exp_cnt  (curve_cnt)
   );

   fan_duty_loop #(
      .DUTY_W (DUTY_W),
      .CNT_W  (CNT_W),
      .HOLD_W (HOLD_W),
      .FLT_W  (FLT_W)
   ) u_loop (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .closed      (closed),
      .manual_duty (manual_duty),
      .exp_cnt     (exp_cnt),
      .fan_count   (fan_count),
      .stop_duty   (stop_duty),
      .start_duty  (start_duty),
      .hold_ticks  (hold_ticks),
      .fault_ticks (fault_ticks),
      .duty        (duty),
      .fan_fault   (fan_fault)
   );

   a_r5_speed_ignores_curve: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_e == FM_SPEED) |-> (exp_cnt == speed_target));
   a_r1_flags_low_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> (!fan_fault && !hot));

endmodule

// File: tb/sim_fan_auto_ctrl.sv
module sim_fan_auto_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic [7:0]  manual_duty = 8'h00;
   logic [15:0] speed_target = 16'd500;
   logic [7:0]  temp_raw = 8'd25;
   logic [6:0]  temp_adj = 7'd0;
   logic [15:0] fan_count = 16'd500;
   logic [7:0]  bnd0 = 8'd40, bnd1 = 8'd50, bnd2 = 8'd90;
   logic [15:0] zcnt0 = 16'd4000, zcnt1 = 16'd3000, zcnt2 = 16'd2000, zcnt3 = 16'd1000;
   logic [7:0]  stop_duty = 8'h20, start_duty = 8'h60;
   logic [15:0] hold_ticks = 16'd3, fault_ticks = 16'd4;
   logic [7:0]  hot_limit = 8'd85, hot_release = 8'd80;
   logic [7:0]  duty;
   logic        hot, fan_fault;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   fan_auto_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .manual_duty(manual_duty),
      .speed_target(speed_target), .temp_raw(temp_raw), .temp_adj(temp_adj),
      .fan_count(fan_count), .bnd0(bnd0), .bnd1(bnd1), .bnd2(bnd2),
      .zcnt0(zcnt0), .zcnt1(zcnt1), .zcnt2(zcnt2), .zcnt3(zcnt3),
      .stop_duty(stop_duty), .start_duty(start_duty), .hold_ticks(hold_ticks),
      .fault_ticks(fault_ticks), .hot_limit(hot_limit), .hot_release(hot_release),
      .duty(duty), .hot(hot), .fan_fault(fan_fault)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic do_tick();
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
   endtask

   task automatic set_manual(input logic [7:0] v);
      mode = 2'b00;
      manual_duty = v;
      step();
      step();
   endtask

   // R3 R4: expected count pinned by equal / one above / one below
   task automatic probe_zone(input logic [7:0] t, input logic [6:0] ofs,
                             input logic [15:0] ecnt, input string req);
      set_manual(8'h80);
      temp_raw = t;
      temp_adj = ofs;
      mode = 2'b10;
      fan_count = ecnt;
      do_tick();
      chk({req, " equal count keeps duty"}, duty, 8'h80);
      fan_count = ecnt + 16'd1;
      do_tick();
      chk({req, " slower raises duty"}, duty, 8'h81);
      fan_count = ecnt - 16'd1;
      do_tick();
      chk({req, " faster lowers duty"}, duty, 8'h80);
   endtask

   task automatic t_reset();
      chk("R1 duty in reset", duty, 8'hFF);
      chk("R1 hot in reset", hot, 1'b0);
      chk("R1 fault in reset", fan_fault, 1'b0);
      @(negedge clk) rst_n = 1'b1;
      mode = 2'b01;
      speed_target = 16'd500;
      fan_count = 16'd500;
      step();
      chk("R1 duty after release", duty, 8'hFF);
   endtask

   task automatic t_manual();
      mode = 2'b00;
      manual_duty = 8'h37;
      step();
      chk("R2 manual duty", duty, 8'h37);
      manual_duty = 8'hC4;
      step();
      chk("R2 manual duty change", duty, 8'hC4);
   endtask

   task automatic t_zones();
      temp_adj = 7'd0;
      probe_zone(8'd30, 7'd0, 16'd4000, "R3 below B0");
      probe_zone(8'd40, 7'd0, 16'd3500, "R3 at B0");
      probe_zone(8'd44, 7'd0, 16'd3500, "R3 below B1");
      probe_zone(8'd45, 7'd0, 16'd3000, "R3 at B1");
      probe_zone(8'd50, 7'd0, 16'd2500, "R3 at B2");
      probe_zone(8'd69, 7'd0, 16'd2500, "R3 below B3");
      probe_zone(8'd70, 7'd0, 16'd2000, "R3 at B3");
      probe_zone(8'd89, 7'd0, 16'd2000, "R3 below B4");
      probe_zone(8'd90, 7'd0, 16'd1000, "R3 at B4");
   endtask

   task automatic t_offset();
      probe_zone(8'd40, 7'h7F, 16'd4000, "R4 minus one");
      probe_zone(8'd85, 7'd5, 16'd1000, "R4 plus five");
      probe_zone(8'd250, 7'h3F, 16'd1000, "R4 clamp high");
      probe_zone(8'd5, 7'h40, 16'd4000, "R4 clamp low");
      temp_adj = 7'd0;
   endtask

   task automatic t_speed();
      set_manual(8'h80);
      temp_raw = 8'd30;
      mode = 2'b01;
      speed_target = 16'd700;
      fan_count = 16'd700;
      do_tick();
      chk("R5 speed equal", duty, 8'h80);
      fan_count = 16'd701;
      do_tick();
      chk("R5 speed slower", duty, 8'h81);
      fan_count = 16'd500;
      do_tick();
      chk("R5 speed faster", duty, 8'h80);
   endtask

   task automatic t_saturate();
      set_manual(8'hFF);
      mode = 2'b01;
      speed_target = 16'd500;
      fan_count = 16'd900;
      do_tick();
      chk("R6 saturate top", duty, 8'hFF);
      stop_duty = 8'h00;
      set_manual(8'h01);
      mode = 2'b01;
      fan_count = 16'd100;
      do_tick();
      chk("R6 step to zero without stop", duty, 8'h00);
      do_tick();
      chk("R6 saturate bottom", duty, 8'h00);
      stop_duty = 8'h20;
      step();
      chk("R6 no tick no change", duty, 8'h00);
   endtask

   task automatic t_force();
      set_manual(8'h80);
      mode = 2'b01;
      fan_count = 16'd100;
      speed_target = 16'hFFFF;
      do_tick();
      chk("R7 FFFF gives off", duty, 8'h00);
      speed_target = 16'h0000;
      do_tick();
      chk("R7 0000 gives full", duty, 8'hFF);
      speed_target = 16'd500;
   endtask

   task automatic t_stop_start();
      set_manual(8'h21);
      mode = 2'b01;
      speed_target = 16'd500;
      fan_count = 16'd400;
      do_tick();
      chk("R8 step to stop duty", duty, 8'h20);
      do_tick();
      chk("R8 stop duty drops to zero", duty, 8'h00);
      fan_count = 16'd600;
      for (int i = 0; i < 3; i++) begin
         do_tick();
         chk("R8 held at zero", duty, 8'h00);
      end
      do_tick();
      chk("R9 kick to start duty", duty, 8'h60);
      for (int i = 0; i < 3; i++) begin
         do_tick();
         chk("R9 held at start duty", duty, 8'h60);
      end
      do_tick();
      chk("R9 loop resumes", duty, 8'h61);
   endtask

   task automatic t_fault();
      set_manual(8'hFF);
      chk("R10 no fault in manual", fan_fault, 1'b0);
      mode = 2'b01;
      speed_target = 16'd500;
      fan_count = 16'd900;
      for (int i = 0; i < 3; i++) begin
         do_tick();
         chk("R10 fault not yet", fan_fault, 1'b0);
      end
      do_tick();
      chk("R10 fault raised", fan_fault, 1'b1);
      fan_count = 16'd400;
      step();
      chk("R10 fault cleared", fan_fault, 1'b0);
   endtask

   task automatic t_hot();
      mode = 2'b00;
      temp_adj = 7'd0;
      temp_raw = 8'd85;
      step();
      chk("R11 at limit not hot", hot, 1'b0);
      temp_raw = 8'd86;
      step();
      chk("R11 above limit hot", hot, 1'b1);
      temp_raw = 8'd80;
      step();
      chk("R11 at release still hot", hot, 1'b1);
      temp_raw = 8'd79;
      step();
      chk("R11 below release clear", hot, 1'b0);
      temp_raw = 8'd82;
      step();
      chk("R11 in band stays clear", hot, 1'b0);
      temp_raw = 8'd80;
      temp_adj = 7'd10;
      step();
      chk("R11 offset makes hot", hot, 1'b1);
      temp_adj = 7'd0;
      temp_raw = 8'd25;
      step();
   endtask

   initial begin
      repeat (3) step();
      t_reset();
      t_manual();
      t_zones();
      t_offset();
      t_speed();
      t_saturate();
      t_force();
      t_stop_start();
      t_fault();
      t_hot();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule